// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit side of a DMA engine. Software lays out a ring of 32-byte descriptors in memory, hands each to the hardware by setting an ownership flag, and then pulses a poll-demand strobe. The walker reads the descriptor at its current pointer. If the hardware owns it, the walker fetches the segment's bytes through a word-wide memory port and streams them out one byte at a time, behind a valid/ready handshake. It then clears the ownership flag in memory and moves its pointer on. It keeps going until it meets a descriptor the hardware does not own, and at that point it goes idle.

A descriptor ends a frame when its last-segment flag is set. The final byte of that segment carries an end-of-frame marker, and a one-cycle completion pulse follows the write-back. The ring wraps when a descriptor carries a wrap flag, not after a fixed count. A poll that arrives while a scan is running is remembered, and it starts one more scan once the current one stops.

Top module: `tdw_ring_walker`

## Requirements
- R1: While reset is low and on the first cycle after it, `mem_req_o`, `tx_valid_o` and `tx_done_o` are all low.
- R2: A poll starts a scan at the current pointer with a read of descriptor word 0 (control). If bit 31 (ownership) of that word is 0, the scan ends after this single read, and no further memory access happens until the next poll.
- R3: For an owned descriptor, the walker reads word 1 (sizes) and then word 2 (buffer address), at pointer+4 and pointer+8. The segment length is word1[11:0] + word1[27:16]. The other size bits are ignored, and lengths above 2048 are accepted. Bytes are emitted starting at the byte address in word 2, which may have any alignment, in little-endian lane order within each word.
- R4: A byte shown on the output stays unchanged, with valid high, until ready is high. No memory read is issued while a byte is waiting on the output.
- R5: `tx_last_o` is high on exactly the final byte of a segment whose control bit 29 is set. `tx_done_o` pulses for one cycle, one cycle after the write-back of such a descriptor is acknowledged.
- R6: After its bytes have been sent, a descriptor gets exactly one write: to word 0 at its own address, carrying the control word with bit 31 cleared and every other bit unchanged.
- R7: After the write-back, the pointer reloads from the base address if control bit 21 is set, and otherwise advances by 32.
- R8: Polls that arrive while a scan is running start exactly one further scan once the current scan ends, however many of them arrive.
- R9: A base-address write loads both the base register and the current pointer.
- R10: A segment of length zero emits no byte, but it is still written back and the pointer still moves.
- R11: A memory request keeps its address, direction and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_i | input | 1 | Poll-demand strobe |
| base_wr_i | input | 1 | Load base address and current pointer |
| base_addr_i | input | AW | Ring base byte address |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | One-cycle acknowledge |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Byte valid |
| tx_last_o | output | 1 | End-of-frame marker on the final byte |
| tx_ready_i | input | 1 | Sink accepts byte |
| tx_done_o | output | 1 | Transmit-complete pulse |

## Verification
The hardest case to reach from the ports is a poll that lands in the middle of a scan. To reach it, the stimulus waits for the first output byte of a long segment and then fires two more polls. The reference model is told to expect one extra scan, which shows up as a single control read at the stopping descriptor. Random ready stalls and random acknowledge delays are combined with unaligned buffers, odd lengths, a zero-length segment and an oversized segment with masked size bits. These combinations exercise every lane and fill case of the byte buffer and every point where a request must be held.

// File: rtl/tdw_pkg.sv
// Package: shared constants and state type of the transmit descriptor walker.
// Assumes 32-bit memory words and the fixed 8-word descriptor layout.
package tdw_pkg;
    localparam int WORD_W     = 32;
    localparam int OWN_BIT    = 31;
    localparam int LAST_BIT   = 29;
    localparam int WRAP_BIT   = 21;
    localparam int SIZE_BITS  = 12;
    localparam int SIZE2_LSB  = 16;
    localparam int DESC_BYTES = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTL,
        ST_SIZE,
        ST_BUF,
        ST_DATA,
        ST_WB
    } walk_st_t;
endpackage

// File: rtl/tdw_poll_latch.sv
// Poll latch: remembers poll strobes until the sequencer takes one.
// Assumes take_i is asserted only when the latch is pending; a poll on the
// same cycle as a take stays pending.
module tdw_poll_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic poll_i,
    input  logic take_i,
    output logic pend_o
);
    logic pend_q;

    // Pending flag: set by any poll, cleared by a take without a new poll.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~take_i) | poll_i;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/tdw_ring_ptr.sv
// Ring pointer: holds the base address and the current descriptor pointer.
// Assumes base writes happen only while the walker is idle.
module tdw_ring_ptr #(
    parameter int AW     = 32,
    parameter int STRIDE = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr_i,
    input  logic [AW-1:0] base_i,
    input  logic          adv_i,
    input  logic          wrap_i,
    output logic [AW-1:0] cur_o
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] cur_q;

    // Pointer update: load on base write, wrap or step after a write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (base_wr_i) begin
            base_q <= base_i;
            cur_q  <= base_i;
        end else if (adv_i) begin
            cur_q  <= wrap_i ? base_q : cur_q + AW'(STRIDE);
        end
    end

    assign cur_o = cur_q;
endmodule

// File: rtl/tdw_byte_streamer.sv
// Byte streamer: fetches one segment word by word and emits it byte by byte.
// Assumes start_i arrives only while idle. It buffers one word and fetches
// the next only after the buffer has drained, so reads wait on ready.
module tdw_byte_streamer #(
    parameter int AW = 32,
    parameter int LW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [LW-1:0] len_i,
    input  logic          last_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [31:0]   rd_data_i,
    output logic [7:0]    tx_data_o,
    output logic          tx_valid_o,
    output logic          tx_last_o,
    input  logic          tx_ready_i,
    output logic          seg_done_o
);
    localparam int LANES  = 4;
    localparam int LANE_W = $clog2(LANES);
    localparam int CNT_W  = LANE_W + 1;

    logic              active_q;
    logic [AW-1:0]     next_q;
    logic [LW-1:0]     rem_q;
    logic [31:0]       word_q;
    logic [LANE_W-1:0] lane_q;
    logic [CNT_W-1:0]  avail_q;
    logic              last_q;
    logic [CNT_W-1:0]  room;
    logic [CNT_W-1:0]  fill;
    logic              fire;

    // Fill size: bytes usable from the next word, limited by what is left.
    always_comb begin
        room = CNT_W'(LANES) - {1'b0, next_q[LANE_W-1:0]};
        fill = (rem_q < LW'(room)) ? rem_q[CNT_W-1:0] : room;
    end

    assign rd_req_o   = active_q && (avail_q == '0) && (rem_q != '0);
    assign rd_addr_o  = {next_q[AW-1:LANE_W], {LANE_W{1'b0}}};
    assign tx_valid_o = (avail_q != '0);
    assign tx_data_o  = word_q[8*lane_q +: 8];
    assign tx_last_o  = tx_valid_o && last_q && (rem_q == LW'(1));
    assign seg_done_o = active_q && (rem_q == '0);
    assign fire       = tx_valid_o && tx_ready_i;

    // Segment state: start, word fills and per-byte consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            next_q   <= '0;
            rem_q    <= '0;
            word_q   <= '0;
            lane_q   <= '0;
            avail_q  <= '0;
            last_q   <= 1'b0;
        end else if (start_i) begin
            active_q <= 1'b1;
            next_q   <= addr_i;
            rem_q    <= len_i;
            avail_q  <= '0;
            last_q   <= last_i;
        end else begin
            if (seg_done_o) active_q <= 1'b0;
            if (rd_req_o && rd_ack_i) begin
                word_q  <= rd_data_i;
                lane_q  <= next_q[LANE_W-1:0];
                avail_q <= fill;
                next_q  <= {next_q[AW-1:LANE_W] + 1'b1, {LANE_W{1'b0}}};
            end else if (fire) begin
                lane_q  <= lane_q + 1'b1;
                avail_q <= avail_q - 1'b1;
                rem_q   <= rem_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdw_ring_walker.sv
// Transmit descriptor ring walker (top). On a poll it walks descriptors from
// the current pointer: reads control, sizes and buffer address, streams the
// segment, writes control back with ownership cleared and moves the pointer.
// It stops at the first descriptor it does not own. Assumes a memory that
// acknowledges each held request once, with read data valid alongside.
module tdw_ring_walker #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          poll_i,
    input  logic          base_wr_i,
    input  logic [AW-1:0] base_addr_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    input  logic [31:0]   mem_rdata_i,
    input  logic          mem_ack_i,
    output logic [7:0]    tx_data_o,
    output logic          tx_valid_o,
    output logic          tx_last_o,
    input  logic          tx_ready_i,
    output logic          tx_done_o
);
    import tdw_pkg::*;

    localparam int LW       = SIZE_BITS + 1;
    localparam int OFS_SIZE = 4;
    localparam int OFS_BUF  = 8;

    walk_st_t      st_q, st_d;
    logic [31:0]   ctl_q;
    logic [LW-1:0] len_q;
    logic          done_q;
    logic          pend, take;
    logic [AW-1:0] cur;
    logic          adv;
    logic          st_start, st_req, st_ack, st_done;
    logic [AW-1:0] st_addr;
    logic [LW-1:0] len_sum;

    tdw_poll_latch u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .poll_i (poll_i),
        .take_i (take),
        .pend_o (pend)
    );

    tdw_ring_ptr #(.AW(AW), .STRIDE(DESC_BYTES)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_wr_i (base_wr_i),
        .base_i    (base_addr_i),
        .adv_i     (adv),
        .wrap_i    (ctl_q[WRAP_BIT]),
        .cur_o     (cur)
    );

    tdw_byte_streamer #(.AW(AW), .LW(LW)) u_strm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (st_start),
        .addr_i     (mem_rdata_i[AW-1:0]),
        .len_i      (len_q),
        .last_i     (ctl_q[LAST_BIT]),
        .rd_req_o   (st_req),
        .rd_addr_o  (st_addr),
        .rd_ack_i   (st_ack),
        .rd_data_i  (mem_rdata_i),
        .tx_data_o  (tx_data_o),
        .tx_valid_o (tx_valid_o),
        .tx_last_o  (tx_last_o),
        .tx_ready_i (tx_ready_i),
        .seg_done_o (st_done)
    );

    assign len_sum  = {1'b0, mem_rdata_i[SIZE_BITS-1:0]}
                    + {1'b0, mem_rdata_i[SIZE2_LSB +: SIZE_BITS]};
    assign take     = (st_q == ST_IDLE) && pend;
    assign st_start = (st_q == ST_BUF) && mem_ack_i;
    assign st_ack   = (st_q == ST_DATA) && mem_ack_i;
    assign adv      = (st_q == ST_WB) && mem_ack_i;

    // Sequencer next state: descriptor fetch, stream, write-back, repeat.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (pend) st_d = ST_CTL;
            ST_CTL:  if (mem_ack_i) st_d = mem_rdata_i[OWN_BIT] ? ST_SIZE : ST_IDLE;
            ST_SIZE: if (mem_ack_i) st_d = ST_BUF;
            ST_BUF:  if (mem_ack_i) st_d = ST_DATA;
            ST_DATA: if (st_done) st_d = ST_WB;
            ST_WB:   if (mem_ack_i) st_d = ST_CTL;
            default: st_d = ST_IDLE;
        endcase
    end

    // Memory port mux: descriptor accesses or streamer reads, by state.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = cur;
        mem_wdata_o = ctl_q & ~(32'd1 << OWN_BIT);
        case (st_q)
            ST_CTL:  mem_req_o = 1'b1;
            ST_SIZE: begin mem_req_o = 1'b1; mem_addr_o = cur + AW'(OFS_SIZE); end
            ST_BUF:  begin mem_req_o = 1'b1; mem_addr_o = cur + AW'(OFS_BUF);  end
            ST_DATA: begin mem_req_o = st_req; mem_addr_o = st_addr; end
            ST_WB:   begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
            default: ;
        endcase
    end

    // Sequencer registers: state, captured control word and segment length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ctl_q <= '0;
            len_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_CTL && mem_ack_i)  ctl_q <= mem_rdata_i;
            if (st_q == ST_SIZE && mem_ack_i) len_q <= len_sum;
        end
    end

    // Completion pulse: one cycle after a last-segment write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= adv && ctl_q[LAST_BIT];
    end

    assign tx_done_o = done_q;
endmodule

// File: rtl/tdw_ring_walker_chk.sv
// Checker: port-level properties of the ring walker, bound to the top.
module tdw_ring_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          poll_i,
    input logic          base_wr_i,
    input logic [AW-1:0] base_addr_i,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [31:0]   mem_wdata_o,
    input logic [31:0]   mem_rdata_i,
    input logic          mem_ack_i,
    input logic [7:0]    tx_data_o,
    input logic          tx_valid_o,
    input logic          tx_last_o,
    input logic          tx_ready_i,
    input logic          tx_done_o
);
    p_hold_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

    p_no_read_while_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_we_o && tx_valid_o |-> 1'b0);

    p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                    && $stable(mem_we_o) && $stable(mem_wdata_o));

    p_wb_clears_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> !mem_wdata_o[31]);

    p_done_after_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |=> !tx_done_o);

    p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_addr_o[1:0] == 2'b00);
endmodule

bind tdw_ring_walker tdw_ring_walker_chk #(.AW(AW)) u_chk (.*);

// File: tb/tdw_ring_walker_tb.sv
`timescale 1ns/1ps
module tdw_ring_walker_tb;
    localparam int AW    = 32;
    localparam int MWORD = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          poll_i = 1'b0;
    logic          base_wr_i = 1'b0;
    logic [AW-1:0] base_addr_i = '0;
    logic          mem_req_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [31:0]   mem_wdata_o;
    logic [31:0]   mem_rdata_i = '0;
    logic          mem_ack_i = 1'b0;
    logic [7:0]    tx_data_o;
    logic          tx_valid_o, tx_last_o;
    logic          tx_ready_i = 1'b1;
    logic          tx_done_o;

    always #4 clk = ~clk;

    tdw_ring_walker #(.AW(AW)) u_dut (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R2";

    logic [31:0] mem  [MWORD];
    logic [31:0] rmem [MWORD];
    logic [64:0] exp_acc [$];
    logic [8:0]  exp_byte [$];
    int exp_done = 0, got_done = 0;
    logic [31:0] m_cur, m_base;
    bit rand_ready = 0;
    logic [15:0] lfsr = 16'hACE1;
    int svc_cnt = 0, dly = 0;

    // Memory responder with 0..2 cycles of acknowledge delay.
    always @(posedge clk) begin
        mem_ack_i <= 1'b0;
        if (mem_req_o && !mem_ack_i) begin
            if (dly == 0) begin
                mem_ack_i <= 1'b1;
                if (mem_we_o) mem[mem_addr_o[11:2]] <= mem_wdata_o;
                else          mem_rdata_i <= mem[mem_addr_o[11:2]];
                svc_cnt = svc_cnt + 1;
                dly = rand_ready ? (svc_cnt % 3) : 0;
            end else begin
                dly = dly - 1;
            end
        end
    end

    // Monitor: drives ready, compares accesses, bytes and pulses.
    bit pend_seen = 0;
    logic [AW-1:0] hold_addr;
    bit prev_stall = 0;
    logic [8:0] prev_byte;
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready_i = rand_ready ? lfsr[0] | lfsr[3] : 1'b1;
        if (rst_n) begin
            if (mem_ack_i) pend_seen = 0;
            else if (mem_req_o) begin
                if (!pend_seen) begin
                    pend_seen = 1;
                    hold_addr = mem_addr_o;
                    checks++;
                    if (exp_acc.size() == 0) begin
                        errors++;
                        $display("FAIL %s unexpected access we=%0b addr=%h expected none",
                                 cur_req, mem_we_o, mem_addr_o);
                    end else begin
                        logic [64:0] e;
                        e = exp_acc.pop_front();
                        if (e[64] != mem_we_o || e[63:32] != mem_addr_o ||
                            (e[64] && e[31:0] != mem_wdata_o)) begin
                            errors++;
                            $display("FAIL %s access actual we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
                                     cur_req, mem_we_o, mem_addr_o, mem_wdata_o, e[64], e[63:32], e[31:0]);
                        end
                    end
                end else begin
                    checks++;
                    if (mem_addr_o != hold_addr) begin
                        errors++;
                        $display("FAIL R11 held address actual %h expected %h", mem_addr_o, hold_addr);
                    end
                end
            end
            if (prev_stall) begin
                checks++;
                if (!tx_valid_o || {tx_last_o, tx_data_o} != prev_byte) begin
                    errors++;
                    $display("FAIL R4 stalled byte actual v=%0b %h expected v=1 %h",
                             tx_valid_o, {tx_last_o, tx_data_o}, prev_byte);
                end
            end
            prev_stall = tx_valid_o && !tx_ready_i;
            prev_byte  = {tx_last_o, tx_data_o};
            if (tx_valid_o && tx_ready_i) begin
                checks++;
                if (exp_byte.size() == 0) begin
                    errors++;
                    $display("FAIL R3 unexpected byte %h expected none", tx_data_o);
                end else begin
                    logic [8:0] b;
                    b = exp_byte.pop_front();
                    if (b[7:0] != tx_data_o) begin
                        errors++;
                        $display("FAIL R3 byte actual %h expected %h", tx_data_o, b[7:0]);
                    end
                    if (b[8] != tx_last_o) begin
                        errors++;
                        $display("FAIL R5 last marker actual %0b expected %0b", tx_last_o, b[8]);
                    end
                end
            end
            if (tx_done_o) got_done++;
        end
    end

    function automatic logic [7:0] rbyte(logic [31:0] a);
        return rmem[a[11:2]][8*a[1:0] +: 8];
    endfunction

    task automatic put_word(logic [31:0] a, logic [31:0] v);
        mem[a[11:2]] = v;
        rmem[a[11:2]] = v;
    endtask

    task automatic set_desc(logic [31:0] a, logic [31:0] ctl, logic [31:0] sz, logic [31:0] b1);
        put_word(a, ctl);
        put_word(a + 4, sz);
        put_word(a + 8, b1);
        for (int i = 3; i < 8; i++) put_word(a + 4 * i, 32'h5A00_0000 + a + i);
    endtask

    task automatic fill_buf(logic [31:0] a, int n, int seed);
        for (int i = 0; i < n; i++) begin
            logic [31:0] p;
            p = a + i;
            mem[p[11:2]][8*p[1:0] +: 8] = 8'((seed + i * 7) & 255);
            rmem[p[11:2]][8*p[1:0] +: 8] = 8'((seed + i * 7) & 255);
        end
    endtask

    // Behavioural ring walk on the model memory; queues expected traffic.
    task automatic model_scan();
        for (int g = 0; g < 64; g++) begin
            logic [31:0] c, s, b, p;
            int len, rem, n;
            c = rmem[m_cur[11:2]];
            exp_acc.push_back({1'b0, m_cur, 32'h0});
            if (!c[31]) return;
            exp_acc.push_back({1'b0, m_cur + 32'd4, 32'h0});
            s = rmem[(m_cur + 4) >> 2];
            len = int'(s[11:0]) + int'(s[27:16]);
            exp_acc.push_back({1'b0, m_cur + 32'd8, 32'h0});
            b = rmem[(m_cur + 8) >> 2];
            p = b;
            rem = len;
            while (rem > 0) begin
                exp_acc.push_back({1'b0, p & ~32'd3, 32'h0});
                n = 4 - int'(p[1:0]);
                if (rem < n) n = rem;
                for (int i = 0; i < n; i++)
                    exp_byte.push_back({c[29] && (rem - i == 1), rbyte(p + i)});
                rem = rem - n;
                p = (p & ~32'd3) + 4;
            end
            c[31] = 1'b0;
            exp_acc.push_back({1'b1, m_cur, c});
            rmem[m_cur[11:2]] = c;
            if (c[29]) exp_done++;
            m_cur = c[21] ? m_base : m_cur + 32;
        end
    endtask

    task automatic write_base(logic [31:0] a);
        @(negedge clk);
        base_addr_i = a; base_wr_i = 1'b1;
        @(negedge clk);
        base_wr_i = 1'b0;
        m_base = a; m_cur = a;
    endtask

    task automatic pulse_poll();
        @(negedge clk); poll_i = 1'b1;
        @(negedge clk); poll_i = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 40) begin
            @(negedge clk);
            if (mem_req_o || tx_valid_o || poll_i) q = 0; else q++;
        end
    endtask

    task automatic end_scenario(string tag);
        checks++;
        if (exp_acc.size() != 0 || exp_byte.size() != 0) begin
            errors++;
            $display("FAIL %s leftover accesses=%0d bytes=%0d expected 0 and 0",
                     tag, exp_acc.size(), exp_byte.size());
            exp_acc.delete(); exp_byte.delete();
        end
        checks++;
        if (got_done != exp_done) begin
            errors++;
            $display("FAIL R5 done pulses actual %0d expected %0d", got_done, exp_done);
        end
        got_done = 0; exp_done = 0;
    endtask

    initial begin
        for (int i = 0; i < MWORD; i++) begin mem[i] = '0; rmem[i] = '0; end
        repeat (5) @(negedge clk);
        // R1: outputs quiet during reset
        checks++;
        if (mem_req_o || tx_valid_o || tx_done_o) begin
            errors++;
            $display("FAIL R1 in reset req=%0b valid=%0b done=%0b expected 0 0 0",
                     mem_req_o, tx_valid_o, tx_done_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (mem_req_o || tx_valid_o || tx_done_o) begin
            errors++;
            $display("FAIL R1 after reset req=%0b valid=%0b done=%0b expected 0 0 0",
                     mem_req_o, tx_valid_o, tx_done_o);
        end

        // R9 and R2: single aligned frame, then stop at unowned descriptor
        cur_req = "R9";
        set_desc(32'h000, 32'hA000_0000, 32'd10, 32'h400);
        set_desc(32'h020, 32'h0000_0000, 32'd4, 32'h500);
        fill_buf(32'h400, 10, 3);
        write_base(32'h000);
        model_scan();
        pulse_poll();
        wait_quiet();
        end_scenario("R9");

        // R3: three-segment frame, unaligned buffers, second size field used
        rand_ready = 1;
        cur_req = "R3";
        set_desc(32'h080, 32'h8000_0000, 32'h0002_0005, 32'h503);
        set_desc(32'h0A0, 32'h8000_0000, 32'd1, 32'h541);
        set_desc(32'h0C0, 32'hA000_0000, 32'd9, 32'h582);
        set_desc(32'h0E0, 32'h0000_0000, 32'd9, 32'h600);
        fill_buf(32'h503, 7, 11);
        fill_buf(32'h541, 1, 40);
        fill_buf(32'h582, 9, 77);
        write_base(32'h080);
        model_scan();
        pulse_poll();
        wait_quiet();
        end_scenario("R3");

        // R7: wrap flag returns to base, which is no longer owned
        cur_req = "R7";
        set_desc(32'h100, 32'hA000_0000, 32'd6, 32'h700);
        set_desc(32'h120, 32'hA020_0000, 32'd5, 32'h722);
        fill_buf(32'h700, 6, 5);
        fill_buf(32'h722, 5, 90);
        write_base(32'h100);
        model_scan();
        pulse_poll();
        wait_quiet();
        end_scenario("R7");

        // R2: first descriptor not owned gives a single read
        cur_req = "R2";
        set_desc(32'h200, 32'h2000_0000, 32'd8, 32'h700);
        write_base(32'h200);
        model_scan();
        pulse_poll();
        wait_quiet();
        end_scenario("R2");

        // R8: polls during a busy scan collapse into one extra scan
        cur_req = "R8";
        set_desc(32'h240, 32'hA000_0000, 32'd40, 32'h800);
        set_desc(32'h260, 32'h0000_0000, 32'd8, 32'h900);
        fill_buf(32'h800, 40, 21);
        write_base(32'h240);
        model_scan();
        model_scan();
        pulse_poll();
        while (!tx_valid_o) @(negedge clk);
        pulse_poll();
        pulse_poll();
        wait_quiet();
        end_scenario("R8");

        // R3: oversize buffer-1 length and masked high size bits
        cur_req = "R3";
        set_desc(32'h280, 32'hA000_0000, 32'h7003_F808, 32'h401);
        set_desc(32'h2A0, 32'h0000_0000, 32'd1, 32'h400);
        fill_buf(32'h401, 2059, 200);
        write_base(32'h280);
        model_scan();
        pulse_poll();
        wait_quiet();
        end_scenario("R3");

        // R10: zero-length segment is written back and skipped over
        cur_req = "R10";
        set_desc(32'h2C0, 32'h8000_0000, 32'h0000_0000, 32'h400);
        set_desc(32'h2E0, 32'hA000_0000, 32'd5, 32'h413);
        set_desc(32'h300, 32'h0000_0000, 32'd5, 32'h400);
        fill_buf(32'h413, 5, 61);
        write_base(32'h2C0);
        model_scan();
        pulse_poll();
        wait_quiet();
        end_scenario("R10");

        // R6: model memory and design memory agree on written-back words
        for (int i = 0; i < MWORD; i++) begin
            if (mem[i] != rmem[i]) begin
                checks++;
                errors++;
                $display("FAIL R6 word %0d actual %h expected %h", i, mem[i], rmem[i]);
            end
        end
        checks++;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog expired, scan did not finish expected completion", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule